// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire serial target that holds a small bank of 8-bit configuration registers and presents every register as a parallel output to the surrounding logic. A host addresses it with the write address byte 0xD2 or the read address byte 0xD3. Transfers are indexed: the host first names a starting register, and the device's internal pointer advances by one after every data byte.

A block write carries the starting index, then a byte count, then the data. Only as many bytes as the count names are stored. A block read first sets the index with a write-addressed phase, then switches direction with a repeated start and the read address. The device answers with a count byte, taken from register 8, and follows it with register contents until the host declines a byte. Read-only and reserved bits keep their values whatever is written to them. Both bus lines pass through a two-flop synchronizer and a glitch filter before any edge is interpreted.

Top module: `cfgsm_smbus_target`

## Requirements
- R1: After reset, register 1 holds 0xFB, register 3 holds 0xEF, register 5 holds 0x1D, register 7 holds 0xFF and register 8 holds 0x0F. All bytes appear on `cfg_regs`, with register k at bits [8k+7:8k].
- R2: The device ACKs the address byte 0xD2 (and 0xD3). Any other address byte is left un-ACKed, with SDA released. The device then ignores the bus until the next start condition.
- R3: In a write, the byte after the address is the starting index N and the next byte is the count X. The data bytes that follow are stored to registers N, N+1, … in turn, and every byte is ACKed.
- R4: Data bytes sent after the X counted bytes are ACKed but are not stored.
- R5: Register 7 and bits [7:4] of register 5 (revision code 0001) are read-only. Bit 2 of register 1 and bit 4 of register 3 are reserved and stay 0. Writes to any of these bits leave them unchanged, and the byte is still ACKed.
- R6: After start, 0xD2, N, repeated start, 0xD3, the device sends the value of register 8 first. It then sends registers N, N+1, … in order, MSB first, moving on after each host ACK.
- R7: A host NACK on a read byte ends the transfer. SDA is released and stays released through the following stop.
- R8: A value written to register 8 becomes the count byte of later reads.
- R9: An index at or beyond the register count (14) hits no register. Writes to such an index are ACKed and discarded, reads return 0x00, and the next transaction behaves normally.
- R10: A stop condition aborts a transfer in progress. The device drives SDA changes only while SCL is low.
- R11: A pulse on SCL or SDA shorter than the filter length (3 clock cycles) is not seen as an edge, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low (open drain) |
| cfg_regs | output | NREG*8 | All configuration registers, register k at [8k+7:8k] |

## Verification
The checker watches four things on every cycle. SDA drive may change only while SCL is low. The read-only bytes and revision nibble must hold fixed. The reserved bits must stay zero. The register bank must come out of reset with its defined values. Everything that depends on a whole bus sequence can only be shown by the bench's scenarios: ACK and NACK decisions, index and count handling, the count byte leading a read, the discarding of excess and out-of-range bytes, recovery after an aborted transfer, and filtering of short pulses.

// File: rtl/cfgsm_pkg.sv
package cfgsm_pkg;

    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 8;
    localparam logic [7:0] ADDR_WRITE = 8'hD2;
    localparam logic [7:0] ADDR_READ  = 8'hD3;
    localparam int CNT_REG   = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_DATA
    } role_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    // Value each register takes on reset.
    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            1:       return 8'hFB;
            2:       return 8'hFF;
            3:       return 8'hEF;
            4:       return 8'h15;
            5:       return 8'h1D;
            6:       return 8'hFF;
            7:       return 8'hFF;
            8:       return 8'h0F;
            9:       return 8'h07;
            10:      return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a bus write may change; the rest are read-only or reserved.
    function automatic logic [7:0] write_mask(input int idx);
        case (idx)
            1:       return 8'hFB;
            3:       return 8'hEF;
            5:       return 8'h0F;
            7:       return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgsm_line_filter.sv
module cfgsm_line_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [1:0]        sync_q;
    logic [STAGES-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[STAGES-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgsm_regbank.sv
module cfgsm_regbank
    import cfgsm_pkg::*;
#(
    parameter int NREG = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              wr,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_data,
    output logic [7:0]           cnt_val,
    output logic [NREG*8-1:0]    regs_flat
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] MASK = write_mask(g);
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= reset_value(g);
            else if (wr.en && wr.idx == IDX_W'(g))
                regs[g] <= (wr.data & MASK) | (regs[g] & ~MASK);
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == IDX_W'(k))
                rd_data = regs[k];
    end

    assign cnt_val = regs[CNT_REG];
endmodule

// File: rtl/cfgsm_bus_engine.sv
module cfgsm_bus_engine
    import cfgsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl,
    input  logic             sda,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_val,
    output logic [IDX_W-1:0] rd_idx,
    output wr_req_t          wr,
    output logic             sda_oe
);
    logic       scl_q, sda_q;
    logic       start_det, stop_det, scl_rise, scl_fall;
    phase_t     phase;
    role_t      role;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [IDX_W-1:0] ptr;
    logic [7:0] remain;
    logic       ack_drv, tx_next, host_ack;

    assign start_det = scl && scl_q && sda_q && !sda;
    assign stop_det  = scl && scl_q && !sda_q && sda;
    assign scl_rise  = scl && !scl_q;
    assign scl_fall  = !scl && scl_q;
    assign rd_idx    = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            phase    <= PH_IDLE;
            role     <= RL_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            remain   <= '0;
            ack_drv  <= 1'b0;
            tx_next  <= 1'b0;
            host_ack <= 1'b0;
            wr       <= '0;
        end else begin
            scl_q  <= scl;
            sda_q  <= sda;
            wr.en  <= 1'b0;
            if (start_det) begin
                phase  <= PH_RX;
                role   <= RL_ADDR;
                bitcnt <= '0;
            end else if (stop_det) begin
                phase <= PH_IDLE;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt  <= '0;
                            phase   <= PH_RX_ACK;
                            ack_drv <= 1'b1;
                            tx_next <= 1'b0;
                            case (role)
                                RL_ADDR: begin
                                    if (shreg == ADDR_WRITE)
                                        role <= RL_INDEX;
                                    else if (shreg == ADDR_READ)
                                        tx_next <= 1'b1;
                                    else
                                        ack_drv <= 1'b0;
                                end
                                RL_INDEX: begin
                                    ptr  <= shreg;
                                    role <= RL_COUNT;
                                end
                                RL_COUNT: begin
                                    remain <= shreg;
                                    role   <= RL_DATA;
                                end
                                default: begin
                                    if (remain != 8'd0) begin
                                        wr.en   <= 1'b1;
                                        wr.idx  <= ptr;
                                        wr.data <= shreg;
                                        remain  <= remain - 8'd1;
                                        ptr     <= ptr + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            bitcnt  <= '0;
                            if (!ack_drv)
                                phase <= PH_IDLE;
                            else if (tx_next) begin
                                phase <= PH_TX;
                                shreg <= cnt_val;
                            end else
                                phase <= PH_RX;
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b1};
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) begin
                                bitcnt <= '0;
                                phase  <= PH_TX_ACK;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (scl_rise)
                            host_ack <= !sda;
                        if (scl_fall) begin
                            if (host_ack) begin
                                phase <= PH_TX;
                                shreg <= rd_data;
                                ptr   <= ptr + 1'b1;
                            end else
                                phase <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (phase)
            PH_RX_ACK: sda_oe = ack_drv;
            PH_TX:     sda_oe = !shreg[7];
            default:   sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgsm_smbus_target.sv
module cfgsm_smbus_target
    import cfgsm_pkg::*;
#(
    parameter int NREG       = 14,
    parameter int GLITCH_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_filt;
    wr_req_t           wr;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_data, cnt_val;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        cfgsm_line_filter #(.STAGES(GLITCH_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[g]),
            .dout (line_filt[g])
        );
    end

    cfgsm_bus_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl     (line_filt[1]),
        .sda     (line_filt[0]),
        .rd_data (rd_data),
        .cnt_val (cnt_val),
        .rd_idx  (rd_idx),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    cfgsm_regbank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .cnt_val   (cnt_val),
        .regs_flat (cfg_regs)
    );
endmodule

// File: rtl/cfgsm_checker.sv
module cfgsm_checker #(
    parameter int NREG = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_regs
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_i) else $error("sda drive changed with SCL high"); // R10

    AST_RO_BYTES_FIXED: assert property (@(posedge clk) disable iff (rst)
        (cfg_regs[63:56] == 8'hFF) && (cfg_regs[47:44] == 4'h1)) else $error("read-only bits moved"); // R5

    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_regs[10] && !cfg_regs[28]) else $error("reserved bit set"); // R5

    AST_RESET_VALUES: assert property (@(posedge clk)
        (rst_q && !rst) |-> (cfg_regs[15:8] == 8'hFB && cfg_regs[31:24] == 8'hEF
                             && cfg_regs[71:64] == 8'h0F && !sda_oe)) else $error("bad reset state"); // R1
endmodule

bind cfgsm_smbus_target cfgsm_checker #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs)
);

// File: tb/cfgsm_smbus_target_tb.sv
module cfgsm_smbus_target_tb;
    localparam int NREG = 14;
    localparam int Q    = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1, sda_h = 1'b1;
    logic sda_oe, sda_bus;
    logic [NREG*8-1:0] cfg_regs;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit glitch_sda = 1'b0, glitch_scl = 1'b0;
    logic [7:0] exp_r [NREG];
    logic [7:0] rbuf [8];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_h & ~sda_oe;

    cfgsm_smbus_target #(.NREG(NREG), .GLITCH_LEN(3)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_bus),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs)
    );

    // Requirement-derived model values (R1, R5).
    function automatic logic [7:0] rst_val(input int i);
        case (i)
            1: return 8'hFB; 2: return 8'hFF; 3: return 8'hEF; 4: return 8'h15;
            5: return 8'h1D; 6: return 8'hFF; 7: return 8'hFF; 8: return 8'h0F;
            9: return 8'h07; 10: return 8'h08; default: return 8'h00;
        endcase
    endfunction
    function automatic logic [7:0] wmask(input int i);
        case (i)
            1: return 8'hFB; 3: return 8'hEF; 5: return 8'h0F; 7: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask
    task automatic bus_rstart();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask
    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i];
            if (glitch_scl && i == 3) begin
                tick(Q/2); scl_h = 1'b1; tick(1); scl_h = 1'b0; tick(Q/2 - 1);
            end else
                tick(Q);
            scl_h = 1'b1;
            if (glitch_sda && i == 3 && b[i]) begin
                tick(Q); sda_h = 1'b0; tick(1); sda_h = 1'b1; tick(Q - 1);
            end else
                tick(2*Q);
            scl_h = 1'b0; tick(Q);
        end
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        ack = !sda_bus;
        tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_h = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q); scl_h = 1'b0;
        end
        tick(Q);
        sda_h = give_ack ? 1'b0 : 1'b1;
        tick(Q); scl_h = 1'b1; tick(2*Q); scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    // Block write: nb data bytes (up to 4), returns number of ACKed bytes.
    task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int nb,
                             input logic [31:0] d, output int acks);
        bit a;
        acks = 0;
        bus_start();
        wr_byte(8'hD2, a); acks += int'(a);
        wr_byte(idx, a);   acks += int'(a);
        wr_byte(cnt, a);   acks += int'(a);
        for (int k = 0; k < nb; k++) begin
            wr_byte(d[31-8*k -: 8], a); acks += int'(a);
            if (k < int'(cnt) && int'(idx) + k < NREG)
                exp_r[int'(idx) + k] = (d[31-8*k -: 8] & wmask(int'(idx) + k))
                                     | (exp_r[int'(idx) + k] & ~wmask(int'(idx) + k));
        end
        bus_stop();
    endtask

    // Block read: rbuf[0] = count byte, rbuf[1..nb] = data.
    task automatic blk_read(input logic [7:0] idx, input int nb, output int acks);
        bit a;
        logic [7:0] b;
        acks = 0;
        bus_start();
        wr_byte(8'hD2, a); acks += int'(a);
        wr_byte(idx, a);   acks += int'(a);
        bus_rstart();
        wr_byte(8'hD3, a); acks += int'(a);
        for (int k = 0; k <= nb; k++) begin
            rd_byte(k != nb, b);
            rbuf[k] = b;
        end
        bus_stop();
    endtask

    // Table: {index, value} single-byte writes walked by one loop (R3, R5).
    localparam logic [15:0] VEC [6] = '{
        {8'd0, 8'hA5}, {8'd1, 8'h00}, {8'd3, 8'hFF},
        {8'd5, 8'hFF}, {8'd7, 8'h00}, {8'd9, 8'h3C}
    };

    initial begin
        int acks;
        bit a;
        logic [NREG*8-1:0] snap;
        for (int i = 0; i < NREG; i++) exp_r[i] = rst_val(i);
        tick(10);
        rst = 1'b0;
        tick(10);

        // R1 reset state
        chk("R1 reg1", cfg_regs[15:8], 8'hFB);
        chk("R1 reg3", cfg_regs[31:24], 8'hEF);
        chk("R1 reg5", cfg_regs[47:40], 8'h1D);
        chk("R1 reg7", cfg_regs[63:56], 8'hFF);
        chk("R1 reg8", cfg_regs[71:64], 8'h0F);
        chk("R1 sda released", sda_oe, 1'b0);

        // Vector table walk: R3 storage, R5 masked bits still ACKed
        for (int v = 0; v < 6; v++) begin
            blk_write(VEC[v][15:8], 8'd1, 1, {VEC[v][7:0], 24'h0}, acks);
            chk("R3/R5 all bytes acked", acks, 4);
            chk("R3/R5 stored value", cfg_regs[int'(VEC[v][15:8])*8 +: 8], exp_r[int'(VEC[v][15:8])]);
        end

        // R6 block read from index 0, count byte first
        blk_read(8'd0, 3, acks);
        chk("R2 read addr acks", acks, 3);
        chk("R6 count byte", rbuf[0], 8'h0F);
        for (int k = 0; k < 3; k++) chk("R6 data order", rbuf[k+1], exp_r[k]);
        // R7 released after NACK and stop
        chk("R7 sda released", sda_oe, 1'b0);
        chk("R7 bus high", sda_bus, 1'b1);

        // R4 excess bytes acked but dropped
        blk_write(8'd10, 8'd2, 3, 32'h11223300, acks);
        chk("R4 all acked", acks, 6);
        chk("R4 reg10", cfg_regs[87:80], 8'h11);
        chk("R4 reg11", cfg_regs[95:88], 8'h22);
        chk("R4 reg12 untouched", cfg_regs[103:96], 8'h00);

        // R8 count register drives count byte
        blk_write(8'd8, 8'd1, 1, 32'h05000000, acks);
        blk_read(8'd10, 2, acks);
        chk("R8 new count byte", rbuf[0], 8'h05);
        chk("R6 read reg10", rbuf[1], 8'h11);
        chk("R6 read reg11", rbuf[2], 8'h22);

        // R9 out-of-range index
        snap = cfg_regs;
        blk_write(8'd20, 8'd2, 2, 32'h55AA0000, acks);
        chk("R9 out-of-range acked", acks, 5);
        chk("R9 bank unchanged", cfg_regs == snap, 1'b1);
        blk_read(8'd20, 1, acks);
        chk("R9 read zero", rbuf[1], 8'h00);
        blk_read(8'd13, 2, acks);
        chk("R9 last reg", rbuf[1], exp_r[13]);
        chk("R9 past end reads zero", rbuf[2], 8'h00);

        // R2 foreign address is NACKed, following bytes ignored
        snap = cfg_regs;
        bus_start();
        wr_byte(8'hA0, a);
        chk("R2 foreign addr nack", a, 1'b0);
        wr_byte(8'h02, a);
        chk("R2 idle after nack", a, 1'b0);
        bus_stop();
        chk("R2 bank unchanged", cfg_regs == snap, 1'b1);

        // R10 stop aborts mid-transfer, next write works
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'd2, a);
        bus_stop();
        chk("R10 aborted no change", cfg_regs[23:16], exp_r[2]);
        blk_write(8'd2, 8'd1, 1, 32'h69000000, acks);
        chk("R10 write after abort", cfg_regs[23:16], 8'h69);

        // R11 short pulses filtered out
        glitch_sda = 1'b1;
        blk_write(8'd9, 8'd1, 1, 32'h5A000000, acks);
        glitch_sda = 1'b0;
        chk("R11 sda glitch acks", acks, 4);
        chk("R11 sda glitch data", cfg_regs[79:72], 8'h5A);
        glitch_scl = 1'b1;
        blk_write(8'd11, 8'd1, 1, 32'h96000000, acks);
        glitch_scl = 1'b0;
        chk("R11 scl glitch acks", acks, 4);
        chk("R11 scl glitch data", cfg_regs[95:88], 8'h96);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule